// File: doc/BRIEF.md
# Lockstep Binary and Calendar Time Core

This core keeps time in two forms that never drift apart. A 32-bit binary counter advances by one on each pulse of a 32.768 kHz clock enable. A BCD calendar holding second, minute, hour, day, month and a two-digit year advances by one second whenever a programmable number N of the counter's low bits wraps to zero. With N set to 15 and the nominal input rate, the calendar therefore steps once per real second. Because the calendar is driven by the counter's own wrap, the binary view and the calendar view always stay in step. The binary view is convenient for time arithmetic. The calendar view is convenient for display.

Software-style writes preload the counter, preload the calendar, or select the mode and N. Counter and calendar writes are staged and take effect on the next tick. A read request copies both live values into shadow registers in a single cycle. The read ports always present one coherent pair, even if a carry ripples through several calendar fields in between.

Top module: `rtc_mixed_core`

## Requirements
- R1: After reset the counter reads 0, the calendar reads year 00, month 01, day 01, 00:00:00, the mode is mixed (code 2) and N is 15. The calendar word is packed as {year, month, day, hour, minute, second}, one BCD byte each, with second in bits 7:0.
- R2: On every cycle with tick high and no staged counter write, the counter increases by one and wraps from 0xFFFFFFFF to 0. Without tick, neither the counter nor the calendar changes.
- R3: The mode code is 0 for binary-only, 1 for calendar-only and 2 for mixed; code 3 acts as binary-only. In mixed mode the calendar advances one second on exactly those increments after which the low N bits of the counter are zero. N is taken from cfgBitSel.
- R4: Seconds and minutes roll from 59 to 00 with a carry to the next field. Hours roll from 23 to 00 with a carry into the day.
- R5: The day rolls to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other long months. Month 12 rolls to 01 with a carry into the year, and year 99 rolls to 00.
- R6: February ends at day 29 when the year value is divisible by 4, and at day 28 otherwise.
- R7: In binary-only mode the counter keeps running and the calendar never advances.
- R8: In calendar-only mode cfgBitSel is ignored and the calendar advances when the low 15 counter bits wrap to zero.
- R9: A counter write is staged and loaded on the next tick. That tick performs no increment and no calendar step.
- R10: A calendar write is staged and loaded on the next tick, replacing any calendar step due on that tick. The counter still increments normally on that tick.
- R11: A cycle with rdSnap high copies the live counter and calendar into cntOut and calOut at the next edge. At all other times cntOut and calOut hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32.768 kHz clock enable, one cycle wide |
| cntWr | input | 1 | Stage a counter write |
| cntWrData | input | 32 | Counter value to load |
| calWr | input | 1 | Stage a calendar write |
| calWrData | input | 48 | Packed BCD calendar value to load |
| cfgWr | input | 1 | Update mode and bit selector |
| cfgMode | input | 2 | Mode code |
| cfgBitSel | input | 5 | Number N of low counter bits per second |
| rdSnap | input | 1 | Copy live time into the read shadows |
| cntOut | output | 32 | Counter shadow |
| calOut | output | 48 | Calendar shadow |

## Verification
The bench runs the same counter preload, just below a wrap of the low N bits, under each of the three modes. This separates the mode that steps the calendar from the one that freezes it and from the one that ignores the selector. Calendar preloads placed one second before the end of a minute, an hour, the end of a 30-day month, the end of February in leap and non-leap years, and the end of the century show whether each carry stops at the right field. Writes staged just before a tick that would have stepped the calendar show whether the written value replaces the step. Ticks issued without a read request show that the shadows stay frozen until the next snapshot.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    MODE_BIN = 2'b00,
    MODE_CAL = 2'b01,
    MODE_MIX = 2'b10,
    MODE_RSV = 2'b11
  } rtcMode_e;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } calTime_t;

  typedef struct packed {
    logic loadCnt;
    logic incCnt;
    logic loadCal;
    logic stepCal;
  } rtcStrobe_t;

  localparam calTime_t CAL_RESET = '{year: 8'h00, month: 8'h01, day: 8'h01,
                                     hour: 8'h00, minute: 8'h00, second: 8'h00};

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] month, input logic [7:0] year);
    logic [6:0] m;
    logic [6:0] y;
    m = bcdToBin(month);
    y = bcdToBin(year);
    case (m)
      7'd4, 7'd6, 7'd9, 7'd11: return 8'h30;
      7'd2:                    return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      default:                 return 8'h31;
    endcase
  endfunction

  function automatic calTime_t calAdvance(input calTime_t c);
    calTime_t n;
    n = c;
    if (c.second != 8'h59) begin
      n.second = bcdInc(c.second);
    end else begin
      n.second = 8'h00;
      if (c.minute != 8'h59) begin
        n.minute = bcdInc(c.minute);
      end else begin
        n.minute = 8'h00;
        if (c.hour != 8'h23) begin
          n.hour = bcdInc(c.hour);
        end else begin
          n.hour = 8'h00;
          if (c.day != lastDay(c.month, c.year)) begin
            n.day = bcdInc(c.day);
          end else begin
            n.day = 8'h01;
            if (c.month != 8'h12) begin
              n.month = bcdInc(c.month);
            end else begin
              n.month = 8'h01;
              n.year  = (c.year == 8'h99) ? 8'h00 : bcdInc(c.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SEL_W    = 5,
  parameter int CAL_BITS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cntWr,
  input  logic             calWr,
  input  logic             cfgWr,
  input  logic [1:0]       cfgMode,
  input  logic [SEL_W-1:0] cfgBitSel,
  input  logic [CNT_W-1:0] cnt,
  output rtcStrobe_t       strb,
  output rtcMode_e         mode
);
  localparam logic [SEL_W-1:0] CAL_SEL = SEL_W'(CAL_BITS);
  localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(CAL_BITS);

  rtcMode_e         modeQ;
  logic [SEL_W-1:0] selQ;
  logic [SEL_W-1:0] effSel;
  logic             pendCnt;
  logic             pendCal;
  logic [CNT_W-1:0] lowMask;
  logic [CNT_W-1:0] nextCnt;
  logic             wrapHit;
  logic             calRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_MIX;
      selQ    <= RST_SEL;
      pendCnt <= 1'b0;
      pendCal <= 1'b0;
    end else begin
      if (cfgWr) begin
        modeQ <= rtcMode_e'(cfgMode);
        selQ  <= cfgBitSel;
      end
      if (cntWr)     pendCnt <= 1'b1;
      else if (tick) pendCnt <= 1'b0;
      if (calWr)     pendCal <= 1'b1;
      else if (tick) pendCal <= 1'b0;
    end
  end

  assign effSel = (modeQ == MODE_CAL) ? CAL_SEL : selQ;

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign lowMask[i] = (32'(effSel) > i);
  end

  assign nextCnt = cnt + CNT_W'(1);
  assign wrapHit = ((nextCnt & lowMask) == '0);
  assign calRun  = (modeQ == MODE_CAL) || (modeQ == MODE_MIX);

  always_comb begin
    strb.loadCnt = tick && pendCnt;
    strb.incCnt  = tick && !pendCnt;
    strb.loadCal = tick && pendCal;
    strb.stepCal = tick && !pendCnt && !pendCal && calRun && wrapHit;
  end

  assign mode = modeQ;
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strb,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             calWr,
  input  calTime_t         calWrData,
  input  logic             rdSnap,
  output logic [CNT_W-1:0] cntLive,
  output calTime_t         calLive,
  output logic [CNT_W-1:0] cntShadow,
  output calTime_t         calShadow
);
  logic [CNT_W-1:0] cntStage;
  calTime_t         calStage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLive   <= '0;
      calLive   <= CAL_RESET;
      cntStage  <= '0;
      calStage  <= CAL_RESET;
      cntShadow <= '0;
      calShadow <= CAL_RESET;
    end else begin
      if (cntWr) cntStage <= cntWrData;
      if (calWr) calStage <= calWrData;

      if (strb.loadCnt)     cntLive <= cntStage;
      else if (strb.incCnt) cntLive <= cntLive + CNT_W'(1);

      if (strb.loadCal)      calLive <= calStage;
      else if (strb.stepCal) calLive <= calAdvance(calLive);

      if (rdSnap) begin
        cntShadow <= cntLive;
        calShadow <= calLive;
      end
    end
  end
endmodule

// File: rtl/rtc_mixed_core.sv
module rtc_mixed_core
  import rtc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SEL_W    = 5,
  parameter int CAL_BITS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             calWr,
  input  logic [47:0]      calWrData,
  input  logic             cfgWr,
  input  logic [1:0]       cfgMode,
  input  logic [SEL_W-1:0] cfgBitSel,
  input  logic             rdSnap,
  output logic [CNT_W-1:0] cntOut,
  output logic [47:0]      calOut
);
  rtcStrobe_t       strb;
  rtcMode_e         modeCur;
  logic [CNT_W-1:0] cntLive;
  calTime_t         calLive;
  calTime_t         calShadow;

  rtc_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W), .CAL_BITS(CAL_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cntWr(cntWr), .calWr(calWr),
    .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgBitSel(cfgBitSel),
    .cnt(cntLive), .strb(strb), .mode(modeCur)
  );

  rtc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntWr(cntWr), .cntWrData(cntWrData),
    .calWr(calWr), .calWrData(calTime_t'(calWrData)),
    .rdSnap(rdSnap),
    .cntLive(cntLive), .calLive(calLive),
    .cntShadow(cntOut), .calShadow(calShadow)
  );

  assign calOut = calShadow;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             rdSnap,
  input rtcStrobe_t       strb,
  input rtcMode_e         modeCur,
  input logic [CNT_W-1:0] cntLive,
  input calTime_t         calLive,
  input logic [CNT_W-1:0] cntOut,
  input logic [47:0]      calOut
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.incCnt |=> cntLive == $past(cntLive) + CNT_W'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(cntLive) && $stable(calLive)));

  assert_mix_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_MIX && strb.stepCal) |=> calLive != $past(calLive));

  assert_bin_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((modeCur == MODE_BIN || modeCur == MODE_RSV) && !strb.loadCal) |=> $stable(calLive));

  assert_counter_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> $stable(calLive) || $past(strb.loadCal));

  assert_snap_copy_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdSnap |=> (cntOut == $past(cntLive) && calOut == 48'($past(calLive))));

  assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rdSnap |=> ($stable(cntOut) && $stable(calOut)));
endmodule

bind rtc_mixed_core rtc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .rdSnap(rdSnap),
  .strb(strb), .modeCur(modeCur),
  .cntLive(cntLive), .calLive(calLive),
  .cntOut(cntOut), .calOut(calOut)
);

// File: tb/tb_rtc_mixed_core.sv
module tb_rtc_mixed_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        cntWr = 1'b0;
  logic [31:0] cntWrData = '0;
  logic        calWr = 1'b0;
  logic [47:0] calWrData = '0;
  logic        cfgWr = 1'b0;
  logic [1:0]  cfgMode = '0;
  logic [4:0]  cfgBitSel = '0;
  logic        rdSnap = 1'b0;
  logic [31:0] cntOut;
  logic [47:0] calOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_mixed_core dut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cntWr(cntWr), .cntWrData(cntWrData),
    .calWr(calWr), .calWrData(calWrData),
    .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgBitSel(cfgBitSel),
    .rdSnap(rdSnap), .cntOut(cntOut), .calOut(calOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk) rdSnap = 1'b1;
    @(negedge clk) rdSnap = 1'b0;
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [4:0] n);
    @(negedge clk) begin cfgWr = 1'b1; cfgMode = m; cfgBitSel = n; end
    @(negedge clk) cfgWr = 1'b0;
  endtask

  task automatic writeCnt(input logic [31:0] v);
    @(negedge clk) begin cntWr = 1'b1; cntWrData = v; end
    @(negedge clk) cntWr = 1'b0;
  endtask

  task automatic writeCal(input logic [47:0] v);
    @(negedge clk) begin calWr = 1'b1; calWrData = v; end
    @(negedge clk) calWr = 1'b0;
  endtask

  task automatic preload(input logic [31:0] c, input logic [47:0] t);
    writeCnt(c);
    writeCal(t);
    pulseTick();
  endtask

  task automatic expectBoth(input string req, input logic [31:0] c, input logic [47:0] t);
    snap();
    check(cntOut == c, req, 64'(cntOut), 64'(c));
    check(calOut == t, req, 64'(calOut), 64'(t));
  endtask

  task automatic testReset();
    check(cntOut == 32'h0, "R1 counter", 64'(cntOut), 64'h0);
    check(calOut == 48'h00_01_01_00_00_00, "R1 calendar", 64'(calOut), 64'h000101000000);
    // default mode mixed with N=15: 0x7FFF -> 0x8000 steps the calendar
    preload(32'h0000_7FFF, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R1 default mode", 32'h0000_8000, 48'h25_06_15_10_20_31);
  endtask

  task automatic testCount();
    setCfg(2'd2, 5'd15);
    preload(32'h0000_1234, 48'h25_06_15_10_20_30);
    pulseTick(); pulseTick(); pulseTick();
    expectBoth("R2 three ticks", 32'h0000_1237, 48'h25_06_15_10_20_30);
    repeat (6) @(negedge clk);
    expectBoth("R2 idle hold", 32'h0000_1237, 48'h25_06_15_10_20_30);
  endtask

  task automatic testMixedStep();
    setCfg(2'd2, 5'd4);
    preload(32'h0000_000E, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R3 before wrap", 32'h0000_000F, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R3 low bits wrap", 32'h0000_0010, 48'h25_06_15_10_20_31);
    preload(32'hFFFF_FFFF, 48'h25_06_15_10_20_40);
    pulseTick();
    expectBoth("R2 R3 full wrap", 32'h0000_0000, 48'h25_06_15_10_20_41);
  endtask

  task automatic stepFrom(input string req, input logic [47:0] t, input logic [47:0] exp);
    preload(32'h0000_000F, t);
    pulseTick();
    snap();
    check(calOut == exp, req, 64'(calOut), 64'(exp));
  endtask

  task automatic testCarries();
    setCfg(2'd2, 5'd4);
    stepFrom("R4 minute carry", 48'h25_01_31_12_58_59, 48'h25_01_31_12_59_00);
    stepFrom("R4 hour carry",   48'h25_01_31_12_59_59, 48'h25_01_31_13_00_00);
    stepFrom("R5 long month",   48'h25_01_31_23_59_59, 48'h25_02_01_00_00_00);
    stepFrom("R5 short month",  48'h25_04_30_23_59_59, 48'h25_05_01_00_00_00);
    stepFrom("R5 mid month",    48'h25_04_29_23_59_59, 48'h25_04_30_00_00_00);
    stepFrom("R5 century",      48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00);
    stepFrom("R6 plain feb",    48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00);
    stepFrom("R6 leap feb 28",  48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00);
    stepFrom("R6 leap feb 29",  48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00);
    stepFrom("R6 year 00 leap", 48'h00_02_28_23_59_59, 48'h00_02_29_00_00_00);
  endtask

  task automatic testBinaryOnly();
    setCfg(2'd0, 5'd4);
    preload(32'h0000_000F, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R7 binary only", 32'h0000_0010, 48'h25_06_15_10_20_30);
  endtask

  task automatic testCalOnly();
    setCfg(2'd1, 5'd4);
    preload(32'h0000_000F, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R8 selector ignored", 32'h0000_0010, 48'h25_06_15_10_20_30);
    preload(32'h0001_7FFF, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R8 fixed 15 bits", 32'h0001_8000, 48'h25_06_15_10_20_31);
  endtask

  task automatic testWrites();
    setCfg(2'd2, 5'd4);
    preload(32'h0000_000F, 48'h25_06_15_10_20_30);
    writeCnt(32'h0000_0100);
    expectBoth("R9 staged only", 32'h0000_000F, 48'h25_06_15_10_20_30);
    pulseTick();
    expectBoth("R9 load replaces step", 32'h0000_0100, 48'h25_06_15_10_20_30);
    preload(32'h0000_000F, 48'h25_06_15_10_20_30);
    writeCal(48'h25_07_01_08_00_00);
    pulseTick();
    expectBoth("R10 load replaces step", 32'h0000_0010, 48'h25_07_01_08_00_00);
  endtask

  task automatic testSnapHold();
    setCfg(2'd2, 5'd4);
    preload(32'h0000_0020, 48'h25_06_15_10_20_30);
    snap();
    pulseTick(); pulseTick();
    check(cntOut == 32'h0000_0020, "R11 counter held", 64'(cntOut), 64'h20);
    check(calOut == 48'h25_06_15_10_20_30, "R11 calendar held", 64'(calOut), 64'h250615102030);
    snap();
    check(cntOut == 32'h0000_0022, "R11 new snapshot", 64'(cntOut), 64'h22);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCount();
    testMixedStep();
    testCarries();
    testBinaryOnly();
    testCalOnly();
    testWrites();
    testSnapHold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule